// File: doc/BRIEF.md
# Floating-Point Load-Multiple Sequencer

This block takes one 32-bit load-multiple instruction word for a floating-point register file and carries it out. When `start` is high and the block is idle, it decodes and classifies the word. It works out the first register index, the register count and the byte offset, and it latches the base register value. It then fetches 32-bit words one at a time through a request/valid memory port. Each word goes to a 32-bit single register, or two words are paired into a 64-bit double register. The order of the pair depends on an endian flag.

After the last register is written, the block can write an updated base address back to the general-purpose register named in the instruction. A `done` pulse then marks the end of the instruction. Words that break the encoding or range rules are not executed. They are reported with an undefined or unpredictable flag together with `done`. The surrounding pipeline evaluates condition codes and access traps before it raises `start`. It also owns the memory and both register files.

Top module: `fpRegLoadSeq`

## Requirements
- R1: A word is executed only if all of the following hold: bits 27:25 = 110, bit 20 = 1, bits 11:9 = 101, and the mode bits {bit 24, bit 23, bit 21} (called P, U, W) are 010, 011 or 101. Bit 8 selects doubles (1) or singles (0), bits 19:16 give the base register number, bit 22 is D, bits 15:12 are Vd and bits 7:0 are the count field imm8.
- R2: Any other value of bits 27:25, bit 20 or bits 11:9 raises `undefFlag`, and so does any other mode value (000, P=1 with W=0, P=U with W=1). `undefFlag` and `unpredFlag` are never high together.
- R3: Among words not undefined, `unpredFlag` is raised when any of these holds: the count is zero; first index plus count exceeds 32; doubles are selected with a count above 16; doubles are selected with imm8 odd and first index plus count above 16; the base register number is 15 with W=1.
- R4: For a flagged word, the flag and `done` are high for exactly the one cycle after the accepting edge. No memory request, register write or base write takes place.
- R5: Reads start at the base value when U=1, or at base minus imm8*4 (modulo 2^32) when U=0. Each later read address is the previous one plus 4.
- R6: For singles, the first index is {Vd, D} and the count is imm8. Each returned word is written to the next register in ascending order on `sWrEn`, in the cycle after its `memValid` edge.
- R7: For doubles, the first index is {D, Vd} and the count is imm8 divided by 2. Each register takes two consecutive words and is written once on `dWrEn`, in ascending order.
- R8: In a double, the first word read fills bits 63:32 when `bigEndian` was high at acceptance. Otherwise it fills bits 31:0.
- R9: When W=1, `baseWrEn` is high for one cycle, in the same cycle as the final register write. It carries the base register number, and base plus imm8*4 when U=1 or base minus imm8*4 when U=0. When W=0, no base write occurs.
- R10: `done` is a single-cycle pulse. For an executed word, it comes one cycle after the final register write. `busy` is high from the cycle after acceptance through the `done` cycle.
- R11: Once raised, `memReq` and `memAddr` stay unchanged until `memValid` is sampled high. Only one read is outstanding at a time.
- R12: `start` is ignored while `busy` is high, and the running instruction completes unchanged.
- R13: After reset, all request, write, flag, `done` and `busy` outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Instruction present; taken when idle |
| instr | input | 32 | Instruction word |
| baseVal | input | 32 | Value of the base general-purpose register |
| bigEndian | input | 1 | Word pairing order for doubles |
| memReq | output | 1 | Read request |
| memAddr | output | 32 | Read byte address |
| memValid | input | 1 | Read data valid, ends the request |
| memData | input | 32 | Read data |
| sWrEn | output | 1 | Single register write strobe |
| sWrIdx | output | 5 | Single register index |
| sWrData | output | 32 | Single register data |
| dWrEn | output | 1 | Double register write strobe |
| dWrIdx | output | 5 | Double register index |
| dWrData | output | 64 | Double register data |
| baseWrEn | output | 1 | Base register write strobe |
| baseWrIdx | output | 4 | Base register number |
| baseWrData | output | 32 | Updated base value |
| undefFlag | output | 1 | Word is undefined |
| unpredFlag | output | 1 | Word is unpredictable |
| done | output | 1 | Instruction finished |
| busy | output | 1 | Instruction in progress |

## Verification
The assertions watch the timing rules that hold on every cycle. A pending request keeps its address until data returns. The two flags never overlap, and a flag always comes with `done` and with no writes. `done` lasts one cycle and follows any base write, and the block is idle after `done`. The address sequence, the register indices, the pairing of words for each endian setting, the writeback value and the classification of each word can only be shown by the bench's scenarios. These scenarios include the odd-imm8 doubles, zero and overlong counts, base register 15 with writeback, decrement-before addressing that wraps below zero, and a `start` raised while busy.

// File: rtl/fpLoadPkg.sv
package fpLoadPkg;
  localparam int WORD_W    = 32;
  localparam int DWORD_W   = 2 * WORD_W;
  localparam int REG_IDX_W = 5;
  localparam int GPR_IDX_W = 4;
  localparam int CNT_W     = 8;
  localparam int NUM_REGS  = 1 << REG_IDX_W;
  localparam int MAX_DBL   = NUM_REGS / 2;
  localparam int WORD_BYTES = WORD_W / 8;
  localparam logic [GPR_IDX_W-1:0] PC_IDX = '1;

  typedef struct packed {
    logic                 isDouble;
    logic                 up;
    logic                 wback;
    logic [REG_IDX_W-1:0] firstIdx;
    logic [CNT_W-1:0]     count;
    logic [GPR_IDX_W-1:0] baseIdx;
    logic [WORD_W-1:0]    offset;
    logic                 undef;
    logic                 unpred;
  } decInfo_t;

  typedef struct packed {
    logic load;
    logic beat;
    logic baseWr;
  } pathCmd_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_WB, ST_DONE, ST_FLAG
  } seqState_t;
endpackage

// File: rtl/fpLoadDecode.sv
module fpLoadDecode import fpLoadPkg::*; (
  input  logic [31:0] instr,
  output decInfo_t    info
);
  logic             pBit, uBit, wBit, dBit, dblSel;
  logic [3:0]       vd;
  logic [CNT_W-1:0] imm8;
  logic [REG_IDX_W-1:0] first;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   span;
  logic             foreign, badMode, rangeBad;

  always_comb begin
    pBit   = instr[24];
    uBit   = instr[23];
    wBit   = instr[21];
    dBit   = instr[22];
    dblSel = instr[8];
    vd     = instr[15:12];
    imm8   = instr[7:0];
    first  = dblSel ? {dBit, vd} : {vd, dBit};
    cnt    = dblSel ? {1'b0, imm8[CNT_W-1:1]} : imm8;
    span   = (CNT_W+1)'(first) + (CNT_W+1)'(cnt);

    foreign = (instr[27:25] != 3'b110) || !instr[20] || (instr[11:9] != 3'b101);
    badMode = (!pBit && !uBit && !wBit) || (pBit && !wBit) || ((pBit == uBit) && wBit);

    rangeBad = (cnt == '0)
            || (span > (CNT_W+1)'(NUM_REGS))
            || (dblSel && (cnt > CNT_W'(MAX_DBL)))
            || (dblSel && imm8[0] && (span > (CNT_W+1)'(MAX_DBL)))
            || ((instr[19:16] == PC_IDX) && wBit);

    info.isDouble = dblSel;
    info.up       = uBit;
    info.wback    = wBit;
    info.firstIdx = first;
    info.count    = cnt;
    info.baseIdx  = instr[19:16];
    info.offset   = {{(WORD_W-CNT_W-2){1'b0}}, imm8, 2'b00};
    info.undef    = foreign || badMode;
    info.unpred   = !(foreign || badMode) && rangeBad;
  end
endmodule

// File: rtl/fpLoadCtrl.sv
module fpLoadCtrl import fpLoadPkg::*; (
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     decUndef,
  input  logic     decUnpred,
  input  logic     memValid,
  input  logic     lastBeat,
  output pathCmd_t cmd,
  output logic     memReq,
  output logic     undefFlag,
  output logic     unpredFlag,
  output logic     done,
  output logic     busy
);
  seqState_t state, nextState;
  logic      heldUndef, heldUnpred;
  logic      accept, rejected;

  assign accept   = (state == ST_IDLE) && start;
  assign rejected = decUndef || decUnpred;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE: if (start) nextState = rejected ? ST_FLAG : ST_READ;
      ST_READ: if (memValid && lastBeat) nextState = ST_WB;
      ST_WB:   nextState = ST_DONE;
      ST_DONE: nextState = ST_IDLE;
      ST_FLAG: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      heldUndef  <= 1'b0;
      heldUnpred <= 1'b0;
    end else begin
      state <= nextState;
      if (accept) begin
        heldUndef  <= decUndef;
        heldUnpred <= decUnpred;
      end
    end
  end

  always_comb begin
    cmd.load   = accept && !rejected;
    cmd.beat   = (state == ST_READ) && memValid;
    cmd.baseWr = (state == ST_WB);
    memReq     = (state == ST_READ);
    done       = (state == ST_DONE) || (state == ST_FLAG);
    undefFlag  = (state == ST_FLAG) && heldUndef;
    unpredFlag = (state == ST_FLAG) && heldUnpred;
    busy       = (state != ST_IDLE);
  end
endmodule

// File: rtl/fpLoadPath.sv
module fpLoadPath import fpLoadPkg::*; (
  input  logic                 clk,
  input  logic                 rstN,
  input  pathCmd_t             cmd,
  input  decInfo_t             info,
  input  logic [WORD_W-1:0]    baseVal,
  input  logic                 bigEndian,
  input  logic [WORD_W-1:0]    memData,
  output logic [WORD_W-1:0]    memAddr,
  output logic                 lastBeat,
  output logic                 sWrEn,
  output logic [REG_IDX_W-1:0] sWrIdx,
  output logic [WORD_W-1:0]    sWrData,
  output logic                 dWrEn,
  output logic [REG_IDX_W-1:0] dWrIdx,
  output logic [DWORD_W-1:0]   dWrData,
  output logic                 baseWrEn,
  output logic [GPR_IDX_W-1:0] baseWrIdx,
  output logic [WORD_W-1:0]    baseWrData
);
  logic [WORD_W-1:0]    addrQ, wbValQ, firstWordQ;
  logic [CNT_W-1:0]     remainQ;
  logic [REG_IDX_W-1:0] curIdxQ;
  logic                 halfQ, dblQ, beQ, wbQ;
  logic [GPR_IDX_W-1:0] baseIdxQ;

  assign memAddr    = addrQ;
  assign lastBeat   = (remainQ == CNT_W'(1)) && (!dblQ || halfQ);
  assign baseWrEn   = cmd.baseWr && wbQ;
  assign baseWrIdx  = baseIdxQ;
  assign baseWrData = wbValQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ      <= '0;
      wbValQ     <= '0;
      firstWordQ <= '0;
      remainQ    <= '0;
      curIdxQ    <= '0;
      halfQ      <= 1'b0;
      dblQ       <= 1'b0;
      beQ        <= 1'b0;
      wbQ        <= 1'b0;
      baseIdxQ   <= '0;
      sWrEn      <= 1'b0;
      sWrIdx     <= '0;
      sWrData    <= '0;
      dWrEn      <= 1'b0;
      dWrIdx     <= '0;
      dWrData    <= '0;
    end else begin
      sWrEn <= 1'b0;
      dWrEn <= 1'b0;
      if (cmd.load) begin
        addrQ    <= info.up ? baseVal : baseVal - info.offset;
        wbValQ   <= info.up ? baseVal + info.offset : baseVal - info.offset;
        remainQ  <= info.count;
        curIdxQ  <= info.firstIdx;
        halfQ    <= 1'b0;
        dblQ     <= info.isDouble;
        beQ      <= bigEndian;
        wbQ      <= info.wback;
        baseIdxQ <= info.baseIdx;
      end else if (cmd.beat) begin
        addrQ <= addrQ + WORD_W'(WORD_BYTES);
        if (!dblQ) begin
          sWrEn   <= 1'b1;
          sWrIdx  <= curIdxQ;
          sWrData <= memData;
          curIdxQ <= curIdxQ + REG_IDX_W'(1);
          remainQ <= remainQ - CNT_W'(1);
        end else if (!halfQ) begin
          firstWordQ <= memData;
          halfQ      <= 1'b1;
        end else begin
          dWrEn   <= 1'b1;
          dWrIdx  <= curIdxQ;
          dWrData <= beQ ? {firstWordQ, memData} : {memData, firstWordQ};
          curIdxQ <= curIdxQ + REG_IDX_W'(1);
          remainQ <= remainQ - CNT_W'(1);
          halfQ   <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/fpRegLoadSeq.sv
module fpRegLoadSeq import fpLoadPkg::*; (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [31:0]          instr,
  input  logic [WORD_W-1:0]    baseVal,
  input  logic                 bigEndian,
  output logic                 memReq,
  output logic [WORD_W-1:0]    memAddr,
  input  logic                 memValid,
  input  logic [WORD_W-1:0]    memData,
  output logic                 sWrEn,
  output logic [REG_IDX_W-1:0] sWrIdx,
  output logic [WORD_W-1:0]    sWrData,
  output logic                 dWrEn,
  output logic [REG_IDX_W-1:0] dWrIdx,
  output logic [DWORD_W-1:0]   dWrData,
  output logic                 baseWrEn,
  output logic [GPR_IDX_W-1:0] baseWrIdx,
  output logic [WORD_W-1:0]    baseWrData,
  output logic                 undefFlag,
  output logic                 unpredFlag,
  output logic                 done,
  output logic                 busy
);
  decInfo_t decInfo;
  pathCmd_t pathCmd;
  logic     lastBeat;

  fpLoadDecode u_decode (
    .instr (instr),
    .info  (decInfo)
  );

  fpLoadCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .decUndef   (decInfo.undef),
    .decUnpred  (decInfo.unpred),
    .memValid   (memValid),
    .lastBeat   (lastBeat),
    .cmd        (pathCmd),
    .memReq     (memReq),
    .undefFlag  (undefFlag),
    .unpredFlag (unpredFlag),
    .done       (done),
    .busy       (busy)
  );

  fpLoadPath u_path (
    .clk        (clk),
    .rstN       (rstN),
    .cmd        (pathCmd),
    .info       (decInfo),
    .baseVal    (baseVal),
    .bigEndian  (bigEndian),
    .memData    (memData),
    .memAddr    (memAddr),
    .lastBeat   (lastBeat),
    .sWrEn      (sWrEn),
    .sWrIdx     (sWrIdx),
    .sWrData    (sWrData),
    .dWrEn      (dWrEn),
    .dWrIdx     (dWrIdx),
    .dWrData    (dWrData),
    .baseWrEn   (baseWrEn),
    .baseWrIdx  (baseWrIdx),
    .baseWrData (baseWrData)
  );
endmodule

// File: rtl/fpRegLoadSeq_chk.sv
module fpRegLoadSeq_chk (
  input logic        clk,
  input logic        rstN,
  input logic        memReq,
  input logic [31:0] memAddr,
  input logic        memValid,
  input logic        sWrEn,
  input logic        dWrEn,
  input logic        baseWrEn,
  input logic        undefFlag,
  input logic        unpredFlag,
  input logic        done,
  input logic        busy
);
  // R11
  memHold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memValid) |=> (memReq && $stable(memAddr)));

  // R11
  reqBusy_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> busy);

  // R2
  flagExcl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(undefFlag && unpredFlag));

  // R4
  flagQuiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (undefFlag || unpredFlag) |-> (done && !memReq && !sWrEn && !dWrEn && !baseWrEn));

  // R6
  onePort_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(sWrEn && dWrEn));

  // R9
  baseThenDone_chk: assert property (@(posedge clk) disable iff (!rstN)
    baseWrEn |=> done);

  // R10
  donePulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R12
  doneIdle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);
endmodule

bind fpRegLoadSeq fpRegLoadSeq_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .memReq     (memReq),
  .memAddr    (memAddr),
  .memValid   (memValid),
  .sWrEn      (sWrEn),
  .dWrEn      (dWrEn),
  .baseWrEn   (baseWrEn),
  .undefFlag  (undefFlag),
  .unpredFlag (unpredFlag),
  .done       (done),
  .busy       (busy)
);

// File: tb/fpRegLoadSeq_tb.sv
`timescale 1ns/1ps
module fpRegLoadSeq_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] baseVal = '0;
  logic        bigEndian = 1'b0;
  logic        memReq;
  logic [31:0] memAddr;
  logic        memValid = 1'b0;
  logic [31:0] memData = '0;
  logic        sWrEn, dWrEn, baseWrEn;
  logic [4:0]  sWrIdx, dWrIdx;
  logic [31:0] sWrData, baseWrData;
  logic [63:0] dWrData;
  logic [3:0]  baseWrIdx;
  logic        undefFlag, unpredFlag, done, busy;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  fpRegLoadSeq u_dut (
    .clk(clk), .rstN(rstN), .start(start), .instr(instr), .baseVal(baseVal),
    .bigEndian(bigEndian), .memReq(memReq), .memAddr(memAddr), .memValid(memValid),
    .memData(memData), .sWrEn(sWrEn), .sWrIdx(sWrIdx), .sWrData(sWrData),
    .dWrEn(dWrEn), .dWrIdx(dWrIdx), .dWrData(dWrData), .baseWrEn(baseWrEn),
    .baseWrIdx(baseWrIdx), .baseWrData(baseWrData), .undefFlag(undefFlag),
    .unpredFlag(unpredFlag), .done(done), .busy(busy)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] memWord(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [31:0] enc(input bit isD, input logic [2:0] puw, input logic [3:0] rn,
                                      input logic [4:0] first, input logic [7:0] imm8);
    logic [3:0] vd;
    logic dB;
    vd = isD ? first[3:0] : first[4:1];
    dB = isD ? first[4] : first[0];
    return {4'hE, 3'b110, puw[2], puw[1], dB, puw[0], 1'b1, rn, vd, 3'b101, isD, imm8};
  endfunction

  task automatic model(input logic [31:0] iw, input logic [31:0] base,
                       output bit exU, output bit exP, output bit isD, output bit wb,
                       output logic [4:0] first, output int cnt,
                       output logic [31:0] startA, output logic [31:0] wbVal);
    logic [2:0] puw;
    logic [31:0] off;
    int span;
    puw   = {iw[24], iw[23], iw[21]};
    isD   = iw[8];
    wb    = iw[21];
    first = isD ? {iw[22], iw[15:12]} : {iw[15:12], iw[22]};
    cnt   = isD ? int'(iw[7:1]) : int'(iw[7:0]);
    off   = {22'b0, iw[7:0], 2'b00};
    span  = int'(first) + cnt;
    exU = (iw[27:25] != 3'b110) || !iw[20] || (iw[11:9] != 3'b101)
       || !(puw == 3'b010 || puw == 3'b011 || puw == 3'b101);
    exP = !exU && (cnt == 0 || span > 32 || (isD && cnt > 16) || (isD && iw[0] && span > 16)
                   || (iw[19:16] == 4'hF && wb));
    startA = iw[23] ? base : base - off;
    wbVal  = iw[23] ? base + off : base - off;
  endtask

  task automatic runInstr(input logic [31:0] iw, input logic [31:0] base, input bit be, input bit poke);
    bit exU, exP, isD, wb, sawReq, sawBase, finished;
    logic [4:0] first;
    int cnt, nWr, nWords, waitCnt, cyc, lastWrCyc, baseCyc;
    logic [31:0] startA, wbVal, w1, w2;
    logic [63:0] expD;
    model(iw, base, exU, exP, isD, wb, first, cnt, startA, wbVal);
    if (exU || exP) poke = 1'b0;
    instr = iw; baseVal = base; bigEndian = be; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    nWr = 0; nWords = 0; cyc = 0; lastWrCyc = -1; baseCyc = -1;
    sawReq = 0; sawBase = 0; finished = 0;
    waitCnt = $urandom % 3;
    while (!finished && cyc < 400) begin
      if (poke && cyc == 1) begin
        start = 1'b1;
        instr = enc(1'b0, 3'b011, 4'd7, 5'd9, 8'd1);
        baseVal = 32'hDEAD_0000;
      end else if (poke && cyc == 2) begin
        start = 1'b0;
      end
      if (memValid) begin
        memValid = 1'b0;
        nWords++;
      end else if (memReq) begin
        sawReq = 1;
        // R5 R11: address sequence and hold while waiting
        chk(memAddr == startA + 32'(nWords * 4), "R5 read address", 64'(memAddr), 64'(startA + 32'(nWords * 4)));
        if (waitCnt == 0) begin
          memValid = 1'b1;
          memData  = memWord(memAddr);
          waitCnt  = $urandom % 3;
        end else begin
          waitCnt--;
        end
      end
      if (sWrEn) begin
        chk(!isD, "R6 single port used for doubles", 64'(sWrEn), 64'(0));
        chk(sWrIdx == 5'(int'(first) + nWr), "R6 single index", 64'(sWrIdx), 64'(5'(int'(first) + nWr)));
        chk(sWrData == memWord(startA + 32'(nWr * 4)), "R6 single data", 64'(sWrData), 64'(memWord(startA + 32'(nWr * 4))));
        nWr++;
        lastWrCyc = cyc;
      end
      if (dWrEn) begin
        w1 = memWord(startA + 32'(nWr * 8));
        w2 = memWord(startA + 32'(nWr * 8 + 4));
        expD = be ? {w1, w2} : {w2, w1};
        chk(isD, "R7 double port used for singles", 64'(dWrEn), 64'(0));
        chk(dWrIdx == 5'(int'(first) + nWr), "R7 double index", 64'(dWrIdx), 64'(5'(int'(first) + nWr)));
        chk(dWrData == expD, "R8 double pairing", dWrData, expD);
        nWr++;
        lastWrCyc = cyc;
      end
      if (baseWrEn) begin
        sawBase = 1;
        baseCyc = cyc;
        chk(baseWrIdx == iw[19:16], "R9 base index", 64'(baseWrIdx), 64'(iw[19:16]));
        chk(baseWrData == wbVal, "R9 base value", 64'(baseWrData), 64'(wbVal));
      end
      if (done) begin
        finished = 1;
        chk(undefFlag == exU, exU ? "R2 undefined flag" : "R1 accepted, undefined flag", 64'(undefFlag), 64'(exU));
        chk(unpredFlag == exP, exP ? "R3 unpredictable flag" : "R1 accepted, unpredictable flag", 64'(unpredFlag), 64'(exP));
        if (exU || exP) begin
          chk(!sawReq && nWr == 0 && !sawBase, "R4 flagged word had activity", 64'({sawReq, sawBase}), 64'(0));
          chk(cyc == 0, "R4 flag timing", 64'(cyc), 64'(0));
        end else begin
          chk(nWr == cnt, isD ? "R7 double count" : "R6 single count", 64'(nWr), 64'(cnt));
          chk(sawBase == wb, "R9 writeback presence", 64'(sawBase), 64'(wb));
          if (wb) chk(baseCyc == lastWrCyc, "R9 writeback timing", 64'(baseCyc), 64'(lastWrCyc));
          chk(cyc == lastWrCyc + 1, "R10 done timing", 64'(cyc), 64'(lastWrCyc + 1));
        end
      end
      cyc++;
      @(negedge clk);
    end
    start = 1'b0;
    memValid = 1'b0;
    if (!finished) chk(1'b0, "R10 done never came", 64'(cyc), 64'(0));
    // R12: no second instruction started by a start raised while busy
    chk(!busy && !done, "R12 idle after done", 64'({busy, done}), 64'(0));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    bit isD, be, poke;
    logic [2:0] puw;
    logic [3:0] rn;
    logic [4:0] first;
    int cnt, sel;
    logic [31:0] iw;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R13 reset state
    chk(!memReq && !sWrEn && !dWrEn && !baseWrEn && !undefFlag && !unpredFlag && !done && !busy,
        "R13 reset outputs", 64'({memReq, sWrEn, dWrEn, baseWrEn, undefFlag, unpredFlag, done, busy}), 64'(0));
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !memReq, "R13 idle after reset", 64'({busy, done, memReq}), 64'(0));

    // directed cases
    runInstr(enc(0, 3'b010, 4'd2, 5'd5, 8'd4), 32'h0000_1000, 1'b0, 1'b0);   // R1 R6
    runInstr(enc(0, 3'b011, 4'd13, 5'd0, 8'd32), 32'h0002_0000, 1'b0, 1'b0); // R6 full file
    runInstr(enc(1, 3'b101, 4'd3, 5'd4, 8'd6), 32'h0000_8000, 1'b1, 1'b0);   // R5 R8 decrement
    runInstr(enc(1, 3'b011, 4'd1, 5'd31, 8'd2), 32'h0000_4000, 1'b0, 1'b0);  // R7 last index
    runInstr(enc(1, 3'b010, 4'd4, 5'd3, 8'd5), 32'h0000_0100, 1'b1, 1'b0);   // R3 odd imm8 legal
    runInstr(enc(1, 3'b010, 4'd4, 5'd15, 8'd5), 32'h0000_0100, 1'b0, 1'b0);  // R3 odd imm8 span
    runInstr(enc(0, 3'b010, 4'd0, 5'd0, 8'd0), 32'h0, 1'b0, 1'b0);           // R3 zero count
    runInstr(enc(0, 3'b010, 4'd0, 5'd20, 8'd13), 32'h0, 1'b0, 1'b0);         // R3 span over 32
    runInstr(enc(1, 3'b010, 4'd0, 5'd0, 8'd34), 32'h0, 1'b0, 1'b0);          // R3 doubles over 16
    runInstr(enc(0, 3'b011, 4'd15, 5'd0, 8'd1), 32'h0, 1'b0, 1'b0);          // R3 base 15 writeback
    runInstr(enc(0, 3'b010, 4'd15, 5'd0, 8'd1), 32'h0000_0040, 1'b0, 1'b0);  // R1 base 15 no writeback
    runInstr(enc(0, 3'b111, 4'd2, 5'd0, 8'd1), 32'h0, 1'b0, 1'b0);           // R2
    runInstr(enc(0, 3'b001, 4'd2, 5'd0, 8'd1), 32'h0, 1'b0, 1'b0);           // R2
    runInstr(enc(0, 3'b000, 4'd2, 5'd0, 8'd1), 32'h0, 1'b0, 1'b0);           // R2
    runInstr(enc(0, 3'b100, 4'd2, 5'd0, 8'd1), 32'h0, 1'b0, 1'b0);           // R2
    runInstr(enc(0, 3'b110, 4'd2, 5'd0, 8'd1), 32'h0, 1'b0, 1'b0);           // R2
    runInstr(enc(0, 3'b010, 4'd2, 5'd0, 8'd1) ^ 32'h0000_0200, 32'h0, 1'b0, 1'b0); // R2 size field
    runInstr(enc(0, 3'b101, 4'd2, 5'd0, 8'd3), 32'h0000_0004, 1'b0, 1'b0);   // R5 wrap below zero
    runInstr(enc(0, 3'b011, 4'd6, 5'd2, 8'd3), 32'h0000_2000, 1'b0, 1'b1);   // R12 start while busy
    runInstr(enc(1, 3'b011, 4'd6, 5'd2, 8'd2), 32'h0000_3000, 1'b1, 1'b1);   // R12 doubles

    // constrained random
    for (int i = 0; i < 160; i++) begin
      isD = 1'($urandom % 2);
      sel = $urandom % 3;
      puw = (sel == 0) ? 3'b010 : (sel == 1) ? 3'b011 : 3'b101;
      rn  = 4'($urandom % 15);
      cnt = isD ? 1 + ($urandom % 16) : 1 + ($urandom % 32);
      first = 5'($urandom % (33 - cnt));
      iw = enc(isD, puw, rn, first, 8'(isD ? 2 * cnt : cnt));
      if (($urandom % 4) == 0) iw = iw ^ (32'h1 << ($urandom % 28));
      be   = 1'($urandom % 2);
      poke = (($urandom % 5) == 0);
      runInstr(iw, $urandom & 32'hFFFF_FFFC, be, poke);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule